// File: doc/BRIEF.md
# Flow-Control Pause Frame Detector

This block sits on the receive path of an Ethernet MAC. It sees the bytes of each received frame one per clock. The first byte comes with a start strobe. A separate end strobe follows the last byte and carries a CRC-good flag. While the bytes arrive, the block compares the fixed header positions against the pattern of a flow-control pause frame and captures the 16-bit pause time. When the end strobe comes, it decides whether the frame was a valid control frame.

The verdict appears one clock after the end strobe, as a set of one-cycle signals:
- a frame-done strobe;
- a control-frame status bit;
- a deliver flag that tells the buffer logic to keep or drop the frame;
- a receive-control event pulse for the interrupt logic;
- when receive flow control is enabled, a pause request that carries the captured pause time to the transmitter.

A forward-all setting decides whether recognised control frames are stored like ordinary traffic or consumed.

Top module: `pause_frame_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to zero at the following edge.
- R2: A frame is a control frame when three conditions hold. First, bytes 0..5 are 01 80 C2 00 00 01 and bytes 12..13 are 88 08 and bytes 14..15 are 00 01, where byte 0 is the one sent with `rx_sof`. Second, at least 18 bytes were received. Third, `rx_crc_ok` is high with `rx_eof`. For such a frame with `cfg_rx_flow` high, `pause_req` is high for the single cycle after the `rx_eof` cycle. In that cycle, `pause_time` equals byte 16 as the high byte and byte 17 as the low byte.
- R3: With `cfg_rx_flow` low, a control frame gives no `pause_req`. It is still reported by `frame_is_ctrl`.
- R4: A frame whose `rx_crc_ok` is low at `rx_eof` is reported as a normal frame: no `pause_req`, `frame_is_ctrl` low, `frame_deliver` high.
- R5: A mismatch in any one byte at positions 0..5 or 12..15 makes the frame a normal frame. Bytes 6..11 and all bytes from 18 onward do not affect the result.
- R6: A frame of 17 or fewer bytes is a normal frame. A matching frame of exactly 18 bytes is a control frame.
- R7: `frame_deliver` is high with `frame_done` for every normal frame. For a control frame it equals `cfg_pass_all`.
- R8: `ctrl_event` pulses with `frame_done` exactly when `frame_is_ctrl` is high. It is low in every other cycle.
- R9: `frame_done` pulses once, in the cycle after an `rx_eof` that follows an `rx_sof`. An `rx_eof` with no open frame produces no output.
- R10: An `rx_sof` in the middle of a frame discards the state of that frame. Parsing restarts with the new byte as byte 0.
- R11: `pause_req`, `frame_done` and `ctrl_event` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_sof | input | 1 | Marks the byte on `rx_data` as byte 0 of a frame |
| rx_valid | input | 1 | `rx_data` holds a frame byte |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End of frame; comes in a cycle after the last byte, with no byte |
| rx_crc_ok | input | 1 | FCS check result, sampled with `rx_eof` |
| cfg_rx_flow | input | 1 | Enables pause requests from received control frames |
| cfg_pass_all | input | 1 | Forward control frames to the receive buffer |
| frame_done | output | 1 | One-cycle verdict strobe |
| frame_is_ctrl | output | 1 | Frame is a valid pause control frame (with `frame_done`) |
| frame_deliver | output | 1 | Frame is to be stored (with `frame_done`) |
| ctrl_event | output | 1 | Receive-control event pulse |
| pause_req | output | 1 | One-cycle pause request to the transmitter |
| pause_time | output | 16 | Pause time quanta, valid with `pause_req` |

## Verification
Directed frames set the boundaries:
- 17 and 18 byte lengths, which separate a length check from a header check;
- an end strobe with no frame open;
- a restart in the middle of a frame, which shows whether stale mismatch state is cleared;
- pause times of all zeros and all ones, which expose byte-order and capture-slot errors.

Random frames then mix valid pause frames with single corrupted header bytes, random source address and padding bytes, random lengths, CRC flags and both configuration bits. These separate a wrong compare position or value from a wrong gating of flow enable, forward-all and CRC.

// File: rtl/pfd_pkg.sv
// Shared constants and helpers for the pause frame detector.
// Assumes byte 0 is the first byte of the destination address.
package pfd_pkg;
    localparam int HDR_LEN    = 18;   // bytes needed to hold the pause time
    localparam int TIME_HI    = 16;
    localparam int TIME_LO    = 17;
    localparam int TIME_W     = 16;
    localparam logic [47:0] CTRL_DA   = 48'h0180_C200_0001;
    localparam logic [15:0] CTRL_TYPE = 16'h8808;
    localparam logic [15:0] PAUSE_OP  = 16'h0001;

    // True for byte positions whose value is fixed in a pause frame
    function automatic logic is_fixed(input int idx);
        return (idx >= 0 && idx < 6) || (idx >= 12 && idx < 16);
    endfunction

    // Expected value at a fixed byte position, high byte first
    function automatic logic [7:0] fixed_val(input int idx);
        logic [47:0] da_sh;
        logic [15:0] w_sh;
        da_sh = '0;
        w_sh  = '0;
        if (idx >= 0 && idx < 6) begin
            da_sh = CTRL_DA >> (8 * (5 - idx));
            return da_sh[7:0];
        end else if (idx == 12 || idx == 13) begin
            w_sh = CTRL_TYPE >> (8 * (13 - idx));
            return w_sh[7:0];
        end else if (idx == 14 || idx == 15) begin
            w_sh = PAUSE_OP >> (8 * (15 - idx));
            return w_sh[7:0];
        end
        return 8'h00;
    endfunction
endpackage

// File: rtl/pfd_byte_counter.sv
// Gives the position of the current byte in its frame.
// The count saturates at LIMIT. A start strobe forces position zero.
// Assumes rx_sof comes together with rx_valid.
module pfd_byte_counter #(
    parameter int LIMIT = 18,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             valid,
    output logic [CNT_W-1:0] idx,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    // Position of the byte present this cycle
    always_comb idx = sof ? '0 : count;

    // Count of bytes seen so far in the open frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (valid)
            count <= (idx == LIM) ? LIM : idx + 1'b1;
        else if (sof)
            count <= '0;
    end
endmodule

// File: rtl/pfd_hdr_match.sv
// Compares the fixed header positions against the pause frame pattern.
// Captures the pause time from bytes 16 and 17.
// The mismatch flag is sticky until the next start strobe.
module pfd_hdr_match
    import pfd_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              valid,
    input  logic [7:0]        data,
    input  logic [CNT_W-1:0]  idx,
    output logic              mismatch,
    output logic [TIME_W-1:0] ptime
);
    logic byte_bad;

    // Wrong value at a fixed position
    always_comb byte_bad = is_fixed(int'(idx)) && (data != fixed_val(int'(idx)));

    // Sticky mismatch, cleared when a new frame starts
    always_ff @(posedge clk) begin
        if (!rst_n)
            mismatch <= 1'b0;
        else if (valid)
            mismatch <= (sof ? 1'b0 : mismatch) | byte_bad;
        else if (sof)
            mismatch <= 1'b0;
    end

    // Capture the two pause time bytes, high byte first
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptime <= '0;
        else if (valid && int'(idx) == TIME_HI)
            ptime[15:8] <= data;
        else if (valid && int'(idx) == TIME_LO)
            ptime[7:0] <= data;
    end
endmodule

// File: rtl/pfd_result.sv
// Turns the parse state into the end-of-frame verdict.
// All outputs are registered pulses that appear the cycle after rx_eof.
// An end strobe only counts when a frame is open.
module pfd_result
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              eof,
    input  logic              len_ok,
    input  logic              mismatch,
    input  logic              crc_ok,
    input  logic              flow_en,
    input  logic              pass_all,
    input  logic [TIME_W-1:0] ptime_in,
    output logic              done,
    output logic              is_ctrl,
    output logic              deliver,
    output logic              ctrl_evt,
    output logic              req,
    output logic [TIME_W-1:0] ptime_out
);
    logic armed;
    logic ctrl_now;
    logic close;

    // Verdict terms for the frame being closed
    always_comb begin
        ctrl_now = !mismatch && len_ok && crc_ok;
        close    = eof && armed;
    end

    // Tracks whether a frame is open
    always_ff @(posedge clk) begin
        if (!rst_n)   armed <= 1'b0;
        else if (sof) armed <= 1'b1;
        else if (eof) armed <= 1'b0;
    end

    // One-cycle verdict pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            is_ctrl  <= 1'b0;
            deliver  <= 1'b0;
            ctrl_evt <= 1'b0;
            req      <= 1'b0;
        end else begin
            done     <= close;
            is_ctrl  <= close && ctrl_now;
            deliver  <= close && (!ctrl_now || pass_all);
            ctrl_evt <= close && ctrl_now;
            req      <= close && ctrl_now && flow_en;
        end
    end

    // Pause time presented with the request
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptime_out <= '0;
        else if (close && ctrl_now && flow_en)
            ptime_out <= ptime_in;
    end
endmodule

// File: rtl/pause_frame_detector.sv
// Top of the pause frame detector. It counts byte positions, checks the
// header, and gives a verdict at the end of each frame.
// Assumes rx_eof comes in a cycle with no byte and no start strobe.
module pause_frame_detector
    import pfd_pkg::*;
#(
    parameter int MIN_LEN = HDR_LEN,
    parameter int CNT_W   = $clog2(MIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_eof,
    input  logic              rx_crc_ok,
    input  logic              cfg_rx_flow,
    input  logic              cfg_pass_all,
    output logic              frame_done,
    output logic              frame_is_ctrl,
    output logic              frame_deliver,
    output logic              ctrl_event,
    output logic              pause_req,
    output logic [TIME_W-1:0] pause_time
);
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  count;
    logic              mismatch;
    logic [TIME_W-1:0] ptime;
    logic              len_ok;

    // Enough bytes seen to hold the pause time
    always_comb len_ok = (count >= CNT_W'(MIN_LEN));

    pfd_byte_counter #(.LIMIT(MIN_LEN), .CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .sof(rx_sof), .valid(rx_valid),
        .idx(idx), .count(count)
    );

    pfd_hdr_match #(.CNT_W(CNT_W)) match_i (
        .clk(clk), .rst_n(rst_n), .sof(rx_sof), .valid(rx_valid),
        .data(rx_data), .idx(idx), .mismatch(mismatch), .ptime(ptime)
    );

    pfd_result res_i (
        .clk(clk), .rst_n(rst_n), .sof(rx_sof), .eof(rx_eof),
        .len_ok(len_ok), .mismatch(mismatch), .crc_ok(rx_crc_ok),
        .flow_en(cfg_rx_flow), .pass_all(cfg_pass_all), .ptime_in(ptime),
        .done(frame_done), .is_ctrl(frame_is_ctrl), .deliver(frame_deliver),
        .ctrl_evt(ctrl_event), .req(pause_req), .ptime_out(pause_time)
    );
endmodule

// File: rtl/pfd_checker.sv
// Port-level properties of the pause frame detector, bound to the top.
module pfd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_eof,
    input logic        rx_crc_ok,
    input logic        cfg_rx_flow,
    input logic        cfg_pass_all,
    input logic        frame_done,
    input logic        frame_is_ctrl,
    input logic        frame_deliver,
    input logic        ctrl_event,
    input logic        pause_req
);
    AST_REQ_IS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> (frame_done && frame_is_ctrl)); // R2
    AST_REQ_NEEDS_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> $past(cfg_rx_flow)); // R3
    AST_REQ_NEEDS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_is_ctrl |-> $past(rx_crc_ok)); // R4
    AST_NORMAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_is_ctrl) |-> frame_deliver); // R7
    AST_CTRL_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
        frame_is_ctrl |-> (frame_deliver == $past(cfg_pass_all))); // R7
    AST_EVT_WITH_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_event |-> frame_is_ctrl); // R8
    AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(rx_eof)); // R9
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |=> !pause_req); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R11
endmodule

bind pause_frame_detector pfd_checker chk_i (
    .clk(clk), .rst_n(rst_n), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok),
    .cfg_rx_flow(cfg_rx_flow), .cfg_pass_all(cfg_pass_all),
    .frame_done(frame_done), .frame_is_ctrl(frame_is_ctrl),
    .frame_deliver(frame_deliver), .ctrl_event(ctrl_event), .pause_req(pause_req)
);

// File: tb/pause_frame_detector_tb_top.sv
module pause_frame_detector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        cfg_rx_flow = 1'b0, cfg_pass_all = 1'b0;
    logic        frame_done, frame_is_ctrl, frame_deliver, ctrl_event, pause_req;
    logic [15:0] pause_time;

    int total = 0;
    int fails = 0;
    logic [7:0] fb [0:63];

    always #10 clk = ~clk; // 50 MHz

    pause_frame_detector dut_i (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok),
        .cfg_rx_flow(cfg_rx_flow), .cfg_pass_all(cfg_pass_all),
        .frame_done(frame_done), .frame_is_ctrl(frame_is_ctrl),
        .frame_deliver(frame_deliver), .ctrl_event(ctrl_event),
        .pause_req(pause_req), .pause_time(pause_time)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Header pattern written out independently of the design
    function automatic logic [7:0] gold(input int i);
        case (i)
            0: return 8'h01;  1: return 8'h80;  2: return 8'hC2;
            3: return 8'h00;  4: return 8'h00;  5: return 8'h01;
            12: return 8'h88; 13: return 8'h08; 14: return 8'h00; 15: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit gold_pos(input int i);
        return (i < 6) || (i >= 12 && i < 16);
    endfunction

    function automatic bit exp_ctrl(input int len, input bit crc);
        if (len < 18 || !crc) return 1'b0;
        for (int i = 0; i < 16; i++)
            if (gold_pos(i) && fb[i] != gold(i)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic build_pause(input logic [15:0] q);
        for (int i = 0; i < 64; i++) fb[i] = gold_pos(i) ? gold(i) : 8'h00;
        for (int i = 6; i < 12; i++) fb[i] = 8'(i * 7 + 3);
        fb[16] = q[15:8];
        fb[17] = q[7:0];
    endtask

    // Sends fb[0..len-1], closes the frame, then checks the verdict
    task automatic send(input int len, input bit crc, input bit flow, input bit pall, input string req);
        bit ctl;
        ctl = exp_ctrl(len, crc);
        @(negedge clk);
        cfg_rx_flow = flow; cfg_pass_all = pall;
        for (int i = 0; i < len; i++) begin
            rx_sof = (i == 0); rx_valid = 1'b1; rx_data = fb[i];
            @(negedge clk);
        end
        rx_sof = 1'b0; rx_valid = 1'b0; rx_eof = 1'b1; rx_crc_ok = crc;
        @(negedge clk);
        rx_eof = 1'b0; rx_crc_ok = 1'b0;
        chk(frame_done, 1, req, "frame_done");
        chk(frame_is_ctrl, ctl, req, "frame_is_ctrl");
        chk(frame_deliver, !ctl || pall, {req, "/R7"}, "frame_deliver");
        chk(ctrl_event, ctl, {req, "/R8"}, "ctrl_event");
        chk(pause_req, ctl && flow, req, "pause_req");
        if (ctl && flow) chk(pause_time, {fb[16], fb[17]}, req, "pause_time");
        @(negedge clk);
        chk({frame_done, pause_req, ctrl_event}, 0, "R11", "pulse cleared");
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int unsigned seed;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({frame_done, frame_is_ctrl, frame_deliver, ctrl_event, pause_req}, 0, "R1", "outputs in reset");
        chk(pause_time, 0, "R1", "pause_time in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: basic pause frame, flow on
        build_pause(16'h1234); send(60, 1, 1, 0, "R2");
        build_pause(16'hFFFF); send(60, 1, 1, 1, "R2");
        build_pause(16'h0000); send(60, 1, 1, 0, "R2");
        // R3: flow off
        build_pause(16'h0042); send(60, 1, 0, 0, "R3");
        // R4: bad CRC
        build_pause(16'h0042); send(60, 0, 1, 0, "R4");
        // R5: opcode mismatch, source and pad don't matter
        build_pause(16'h0005); fb[15] = 8'h02; send(60, 1, 1, 0, "R5");
        build_pause(16'h0005); fb[8] = 8'hAA; fb[40] = 8'h55; send(60, 1, 1, 0, "R5");
        // R6: length boundaries
        build_pause(16'h0777); send(17, 1, 1, 0, "R6");
        build_pause(16'h0777); send(18, 1, 1, 0, "R6");

        // R9: end strobe with no open frame
        @(negedge clk); rx_eof = 1'b1; rx_crc_ok = 1'b1;
        @(negedge clk); rx_eof = 1'b0; rx_crc_ok = 1'b0;
        chk(frame_done, 0, "R9", "stray eof done");
        chk(pause_req, 0, "R9", "stray eof req");

        // R10: restart mid-frame after a bad header byte
        @(negedge clk);
        cfg_rx_flow = 1'b1;
        for (int i = 0; i < 5; i++) begin
            rx_sof = (i == 0); rx_valid = 1'b1; rx_data = 8'hEE;
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0;
        build_pause(16'h0A0B); send(60, 1, 1, 0, "R10");

        // Random mix
        for (int n = 0; n < 60; n++) begin
            int len;
            int pick;
            build_pause(16'($urandom));
            for (int i = 6; i < 12; i++) fb[i] = 8'($urandom);
            for (int i = 18; i < 64; i++) fb[i] = 8'($urandom);
            if ($urandom_range(0, 2) == 0) begin
                pick = $urandom_range(0, 9);
                pick = (pick < 6) ? pick : pick + 6;
                fb[pick] = fb[pick] ^ 8'(1 << $urandom_range(0, 7));
            end
            pick = $urandom_range(0, 3);
            len = (pick == 0) ? 17 : (pick == 1) ? 18 : (pick == 2) ? 60 : 64;
            send(len, $urandom_range(0, 3) != 0, 1'($urandom), 1'($urandom), "R2/R5");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule